// File: doc/BRIEF.md
# Accumulator Datapath With Link Flag

This block holds a 16-bit working accumulator together with a single link flag that extends it by one bit. Each clock it applies at most one operation chosen by a set of plain strobes: a load strobe that takes one of seven computed results (selected by a one-hot operation vector), a clear strobe, an increment strobe, and two strobes that act only on the link flag. The loaded result is formed by gating every candidate result with its select bit and OR-ing the gated words, so the select vector must be one-hot.

The block drives the accumulator, the link flag and three status bits that a sequencer uses for conditional skips: accumulator is zero, accumulator bit 15 (sign), and link flag is zero. A cycle whose strobes do not name exactly one legal operation leaves all state untouched and raises an error flag for one cycle. The surrounding sequencer owns timing, bus steering and memory access. All control pins are plain levels sampled on the rising edge; there is no back-pressure.

Top module: `acc_link_alu`

## Requirements
- R1: While rst_n is low, ac_o is 0, e_o is 0 and err_o is 0.
- R2: Load with op_i = 7'b0000001 (bit 0, AND) sets ac_o to ac_o AND dr_i at the next edge; e_o is unchanged.
- R3: Load with op_i bit 1 (ADD) sets ac_o to the low 16 bits of ac_o + dr_i and e_o to the carry out of bit 15.
- R4: Load with op_i bit 2 copies dr_i into ac_o; load with op_i bit 3 copies inp_i into ac_o; e_o is unchanged by both.
- R5: Load with op_i bit 4 sets ac_o to its bitwise complement; e_o is unchanged.
- R6: Load with op_i bit 5 (rotate right through link) sets ac_o to {e_o, ac_o[15:1]} and e_o to the old ac_o[0].
- R7: Load with op_i bit 6 (rotate left through link) sets ac_o to {ac_o[14:0], e_o} and e_o to the old ac_o[15].
- R8: ac_clr_i sets ac_o to 0; ac_inc_i sets ac_o to ac_o + 1 modulo 2^16, with the carry discarded; e_o is unchanged by both.
- R9: e_cmp_i inverts e_o and e_clr_i sets e_o to 0; ac_o is unchanged by both.
- R10: With none of ac_ld_i, ac_clr_i, ac_inc_i, e_cmp_i, e_clr_i high, ac_o and e_o hold, whatever op_i carries.
- R11: If more than one of the five strobes is high, or ac_ld_i is high with op_i not one-hot, ac_o and e_o hold and err_o is 1 in the following cycle; after any other cycle err_o is 0.
- R12: ac_zero_o is 1 exactly when ac_o is 0, ac_neg_o equals ac_o[15], and e_zero_o is 1 exactly when e_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dr_i | input | 16 | Data operand word |
| inp_i | input | 16 | Input-device word |
| ac_ld_i | input | 1 | Load the result selected by op_i |
| op_i | input | 7 | One-hot operation select for a load |
| ac_clr_i | input | 1 | Clear the accumulator |
| ac_inc_i | input | 1 | Increment the accumulator |
| e_cmp_i | input | 1 | Invert the link flag |
| e_clr_i | input | 1 | Clear the link flag |
| ac_o | output | 16 | Accumulator |
| e_o | output | 1 | Link flag |
| ac_zero_o | output | 1 | Accumulator equals zero |
| ac_neg_o | output | 1 | Accumulator bit 15 |
| e_zero_o | output | 1 | Link flag is zero |
| err_o | output | 1 | Previous cycle had an illegal strobe combination |

## Verification
The hardest cases are the ones a well-behaved sequencer never produces: a load with an all-zero or two-hot select, or two strobes colliding, which would corrupt the OR-combined result if the hold path failed. The stimulus forces each such pattern directly between legal operations so that any state change or a stuck error flag shows up at once. Carry into the link flag and its round trip through the rotates are reached by preloading boundary words (all ones, single top or bottom bit) through the transfer operations before adding or rotating.

// File: rtl/acc_link_pkg.sv
package acc_link_pkg;
  localparam int unsigned ACC_W = 16;
  localparam int unsigned N_OPS = 7;
  localparam int unsigned N_STB = 5;

  typedef enum int unsigned {
    OP_AND  = 0,
    OP_ADD  = 1,
    OP_DR   = 2,
    OP_INP  = 3,
    OP_COM  = 4,
    OP_ROR  = 5,
    OP_ROL  = 6
  } op_idx_e;
endpackage

// File: rtl/acc_strobe_check.sv
module acc_strobe_check #(
  parameter int unsigned NSTB = 5,
  parameter int unsigned NOPS = 7
) (
  input  logic [NSTB-1:0] stb_i,
  input  logic            ld_i,
  input  logic [NOPS-1:0] op_i,
  output logic            bad_o
);
  localparam int unsigned CW = $clog2(NOPS + NSTB + 1);

  logic [CW-1:0] stb_cnt;
  logic [CW-1:0] op_cnt;

  always_comb begin
    stb_cnt = '0;
    for (int i = 0; i < int'(NSTB); i++) stb_cnt = stb_cnt + CW'(stb_i[i]);
    op_cnt = '0;
    for (int j = 0; j < int'(NOPS); j++) op_cnt = op_cnt + CW'(op_i[j]);
  end

  assign bad_o = (stb_cnt > CW'(1)) || (ld_i && (op_cnt != CW'(1)));
endmodule

// File: rtl/acc_term_mux.sv
module acc_term_mux #(
  parameter int unsigned W    = 16,
  parameter int unsigned NOPS = 7
) (
  input  logic [W-1:0]    ac_i,
  input  logic            e_i,
  input  logic [W-1:0]    dr_i,
  input  logic [W-1:0]    inp_i,
  input  logic [NOPS-1:0] sel_i,
  output logic [W-1:0]    ac_ld_o,
  output logic            e_ld_o
);
  import acc_link_pkg::*;

  logic [W-1:0] term  [NOPS];
  logic         eterm [NOPS];
  logic [W:0]   sum;
  logic [W-1:0] acc_or [NOPS+1];
  logic         e_or   [NOPS+1];
  logic         e_keep;

  assign sum = {1'b0, ac_i} + {1'b0, dr_i};

  always_comb begin
    for (int k = 0; k < int'(NOPS); k++) begin
      term[k]  = '0;
      eterm[k] = 1'b0;
    end
    term[OP_AND]  = ac_i & dr_i;
    term[OP_ADD]  = sum[W-1:0];
    eterm[OP_ADD] = sum[W];
    term[OP_DR]   = dr_i;
    term[OP_INP]  = inp_i;
    term[OP_COM]  = ~ac_i;
    term[OP_ROR]  = {e_i, ac_i[W-1:1]};
    eterm[OP_ROR] = ac_i[0];
    term[OP_ROL]  = {ac_i[W-2:0], e_i};
    eterm[OP_ROL] = ac_i[W-1];
  end

  // ops that do not touch the link pass the old value through
  assign e_keep = sel_i[OP_AND] | sel_i[OP_DR] | sel_i[OP_INP] | sel_i[OP_COM];

  assign acc_or[0] = '0;
  assign e_or[0]   = e_keep & e_i;

  for (genvar g = 0; g < int'(NOPS); g++) begin : g_gate
    assign acc_or[g+1] = acc_or[g] | (term[g] & {W{sel_i[g]}});
    assign e_or[g+1]   = e_or[g]   | (eterm[g] & sel_i[g]);
  end

  assign ac_ld_o = acc_or[NOPS];
  assign e_ld_o  = e_or[NOPS];
endmodule

// File: rtl/acc_status.sv
module acc_status #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] ac_i,
  input  logic         e_i,
  output logic         zero_o,
  output logic         neg_o,
  output logic         ezero_o
);
  assign zero_o  = ~|ac_i;
  assign neg_o   = ac_i[W-1];
  assign ezero_o = ~e_i;
endmodule

// File: rtl/acc_link_alu.sv
module acc_link_alu
  import acc_link_pkg::*;
#(
  parameter int unsigned W    = ACC_W,
  parameter int unsigned NOPS = N_OPS
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [W-1:0]    dr_i,
  input  logic [W-1:0]    inp_i,
  input  logic            ac_ld_i,
  input  logic [NOPS-1:0] op_i,
  input  logic            ac_clr_i,
  input  logic            ac_inc_i,
  input  logic            e_cmp_i,
  input  logic            e_clr_i,
  output logic [W-1:0]    ac_o,
  output logic            e_o,
  output logic            ac_zero_o,
  output logic            ac_neg_o,
  output logic            e_zero_o,
  output logic            err_o
);
  localparam int unsigned NSTB = N_STB;

  logic [W-1:0]    ac_q, ac_d, ld_val;
  logic            e_q, e_d, e_ld;
  logic            err_q, bad;
  logic [NSTB-1:0] stb;

  assign stb = {ac_ld_i, ac_clr_i, ac_inc_i, e_cmp_i, e_clr_i};

  acc_strobe_check #(.NSTB(NSTB), .NOPS(NOPS)) u_chk_stb (
    .stb_i (stb),
    .ld_i  (ac_ld_i),
    .op_i  (op_i),
    .bad_o (bad)
  );

  acc_term_mux #(.W(W), .NOPS(NOPS)) u_terms (
    .ac_i    (ac_q),
    .e_i     (e_q),
    .dr_i    (dr_i),
    .inp_i   (inp_i),
    .sel_i   (op_i),
    .ac_ld_o (ld_val),
    .e_ld_o  (e_ld)
  );

  always_comb begin
    ac_d = ac_q;
    e_d  = e_q;
    if (!bad) begin
      if (ac_ld_i) begin
        ac_d = ld_val;
        e_d  = e_ld;
      end else if (ac_clr_i) begin
        ac_d = '0;
      end else if (ac_inc_i) begin
        ac_d = ac_q + W'(1);
      end else if (e_cmp_i) begin
        e_d = ~e_q;
      end else if (e_clr_i) begin
        e_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ac_q  <= '0;
      e_q   <= 1'b0;
      err_q <= 1'b0;
    end else begin
      ac_q  <= ac_d;
      e_q   <= e_d;
      err_q <= bad;
    end
  end

  acc_status #(.W(W)) u_status (
    .ac_i    (ac_q),
    .e_i     (e_q),
    .zero_o  (ac_zero_o),
    .neg_o   (ac_neg_o),
    .ezero_o (e_zero_o)
  );

  assign ac_o  = ac_q;
  assign e_o   = e_q;
  assign err_o = err_q;
endmodule

// File: rtl/acc_link_alu_chk.sv
module acc_link_alu_chk #(
  parameter int unsigned W    = 16,
  parameter int unsigned NOPS = 7
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ac_ld_i,
  input logic [NOPS-1:0] op_i,
  input logic            ac_clr_i,
  input logic            ac_inc_i,
  input logic            e_cmp_i,
  input logic            e_clr_i,
  input logic [W-1:0]    ac_o,
  input logic            e_o,
  input logic            err_o
);
  logic [4:0] stb;
  logic       idle, illegal, only;
  assign stb     = {ac_ld_i, ac_clr_i, ac_inc_i, e_cmp_i, e_clr_i};
  assign idle    = (stb == 5'b0);
  assign illegal = ($countones(stb) > 1) || (ac_ld_i && !$onehot(op_i));
  assign only    = !illegal;

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    idle |=> ($stable(ac_o) && $stable(e_o))); // R10

  AST_ILLEGAL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |=> ($stable(ac_o) && $stable(e_o) && err_o)); // R11

  AST_ERR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    only |=> !err_o); // R11

  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (only && ac_clr_i) |=> (ac_o == '0 && $stable(e_o))); // R8

  AST_ROR_LINK: assert property (@(posedge clk) disable iff (!rst_n)
    (only && ac_ld_i && op_i[5]) |=> (e_o == $past(ac_o[0]))); // R6

  AST_ROL_LINK: assert property (@(posedge clk) disable iff (!rst_n)
    (only && ac_ld_i && op_i[6]) |=> (e_o == $past(ac_o[W-1]))); // R7

  AST_ECMP_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (only && e_cmp_i) |=> (e_o != $past(e_o) && $stable(ac_o))); // R9
endmodule

bind acc_link_alu acc_link_alu_chk #(.W(W), .NOPS(NOPS)) u_assert (
  .clk(clk), .rst_n(rst_n), .ac_ld_i(ac_ld_i), .op_i(op_i),
  .ac_clr_i(ac_clr_i), .ac_inc_i(ac_inc_i), .e_cmp_i(e_cmp_i),
  .e_clr_i(e_clr_i), .ac_o(ac_o), .e_o(e_o), .err_o(err_o)
);

// File: tb/sim_acc_link_alu.sv
`timescale 1ns/1ps
module sim_acc_link_alu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] dr_i = '0, inp_i = '0;
  logic        ac_ld_i = 0, ac_clr_i = 0, ac_inc_i = 0, e_cmp_i = 0, e_clr_i = 0;
  logic [6:0]  op_i = '0;
  logic [15:0] ac_o;
  logic        e_o, ac_zero_o, ac_neg_o, e_zero_o, err_o;

  int n_chk = 0, n_fail = 0;
  int unsigned m_ac = 0;
  int unsigned m_e = 0;
  int unsigned m_err = 0;

  always #2.5 clk = ~clk;

  acc_link_alu u0 (
    .clk(clk), .rst_n(rst_n), .dr_i(dr_i), .inp_i(inp_i),
    .ac_ld_i(ac_ld_i), .op_i(op_i), .ac_clr_i(ac_clr_i), .ac_inc_i(ac_inc_i),
    .e_cmp_i(e_cmp_i), .e_clr_i(e_clr_i), .ac_o(ac_o), .e_o(e_o),
    .ac_zero_o(ac_zero_o), .ac_neg_o(ac_neg_o), .e_zero_o(e_zero_o), .err_o(err_o)
  );

  task automatic chk(input string tag, input string what, input int unsigned got, input int unsigned exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
    end
  endtask

  task automatic compare(input string tag);
    chk(tag, "ac", ac_o, m_ac);
    chk(tag, "e", e_o, m_e);
    chk(tag, "err", err_o, m_err);
    chk("R12", "zero", ac_zero_o, (m_ac == 0) ? 1 : 0);
    chk("R12", "neg", ac_neg_o, (m_ac >> 15) & 1);
    chk("R12", "ezero", e_zero_o, (m_e == 0) ? 1 : 0);
  endtask

  // behavioural reference, one call per clock
  task automatic model();
    int nstb, nop;
    int unsigned s;
    nstb = ac_ld_i + ac_clr_i + ac_inc_i + e_cmp_i + e_clr_i;
    nop = 0;
    for (int i = 0; i < 7; i++) nop += op_i[i];
    if (nstb > 1 || (ac_ld_i && nop != 1)) begin
      m_err = 1;
      return;
    end
    m_err = 0;
    if (ac_ld_i) begin
      if (op_i[0]) m_ac = m_ac & dr_i;
      else if (op_i[1]) begin
        s = m_ac + dr_i; m_ac = s % 65536; m_e = s / 65536;
      end
      else if (op_i[2]) m_ac = dr_i;
      else if (op_i[3]) m_ac = inp_i;
      else if (op_i[4]) m_ac = 16'hFFFF - m_ac;
      else if (op_i[5]) begin
        s = m_ac % 2; m_ac = m_ac / 2 + m_e * 32768; m_e = s;
      end else begin
        s = m_ac / 32768; m_ac = (m_ac * 2) % 65536 + m_e; m_e = s;
      end
    end
    else if (ac_clr_i) m_ac = 0;
    else if (ac_inc_i) m_ac = (m_ac + 1) % 65536;
    else if (e_cmp_i) m_e = 1 - m_e;
    else if (e_clr_i) m_e = 0;
  endtask

  task automatic step(input string tag, input logic ld, input logic [6:0] op,
                      input logic clr, input logic inc, input logic cm, input logic ce,
                      input logic [15:0] d, input logic [15:0] inp);
    @(negedge clk);
    ac_ld_i = ld; op_i = op; ac_clr_i = clr; ac_inc_i = inc;
    e_cmp_i = cm; e_clr_i = ce; dr_i = d; inp_i = inp;
    model();
    @(posedge clk); #1;
    compare(tag);
  endtask

  task automatic ld(input string tag, input int b, input logic [15:0] d);
    step(tag, 1, 7'(1 << b), 0, 0, 0, 0, d, ~d);
  endtask

  initial begin
    #(5.0 * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired: got hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1; compare("R1");
    rst_n = 1'b1;
    step("R4", 1, 7'b0001000, 0, 0, 0, 0, 16'h0, 16'h1234);   // input transfer
    ld("R4", 2, 16'hFFFF);                                      // data transfer
    ld("R3", 1, 16'h0001);                                      // FFFF+1 -> 0, carry
    ld("R4", 2, 16'h8001);
    ld("R6", 5, 16'h0);                                         // e=1 in top, bit0 to e
    ld("R7", 6, 16'h0);
    ld("R7", 6, 16'h0);
    ld("R2", 0, 16'h0F0F);
    ld("R5", 4, 16'h0);
    step("R9", 0, 0, 0, 0, 1, 0, 16'h0, 16'h0);
    step("R9", 0, 0, 0, 0, 0, 1, 16'h0, 16'h0);
    step("R8", 0, 0, 0, 0, 1, 0, 16'h0, 16'h0);                 // set e before inc
    ld("R4", 2, 16'hFFFF);
    step("R8", 0, 0, 0, 1, 0, 0, 16'h0, 16'h0);                 // wrap, e kept
    ld("R4", 2, 16'h7FFF);
    step("R8", 0, 0, 0, 1, 0, 0, 16'h0, 16'h0);
    step("R8", 0, 0, 1, 0, 0, 0, 16'h0, 16'h0);
    step("R10", 0, 7'b1111111, 0, 0, 0, 0, 16'hAAAA, 16'h5555);
    ld("R4", 2, 16'h1357);
    step("R11", 0, 0, 1, 1, 0, 0, 16'h0, 16'h0);
    step("R11", 1, 7'b0000011, 0, 0, 0, 0, 16'hFFFF, 16'h0);
    step("R11", 1, 7'b0000000, 0, 0, 0, 0, 16'hFFFF, 16'h0);
    step("R11", 1, 7'b0000100, 0, 0, 1, 0, 16'hFFFF, 16'h0);
    step("R11", 0, 0, 0, 0, 0, 0, 16'h0, 16'h0);
    for (int k = 0; k < 2000; k++) begin
      int unsigned r;
      r = $urandom % 16;
      if (r < 7) ld("R3", int'(r), 16'($urandom));
      else if (r == 7) step("R8", 0, 0, 1, 0, 0, 0, 16'h0, 16'h0);
      else if (r < 10) step("R8", 0, 0, 0, 1, 0, 0, 16'h0, 16'h0);
      else if (r == 10) step("R9", 0, 0, 0, 0, 1, 0, 16'h0, 16'h0);
      else if (r == 11) step("R9", 0, 0, 0, 0, 0, 1, 16'h0, 16'h0);
      else if (r == 12) step("R10", 0, 7'($urandom), 0, 0, 0, 0, 16'($urandom), 16'h0);
      else step("R11", 1'($urandom), 7'($urandom), 1'($urandom), 1'($urandom),
                1'($urandom), 1'($urandom), 16'($urandom), 16'($urandom));
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule